// File: doc/BRIEF.md
# Receive FIFO with Scaled Interrupt Threshold

This block is the receive side buffer of a serial port: it takes bytes that a deserializer has already assembled, holds them in arrival order and lets a host pop them one at a time. The store can be configured for a large depth of 128 bytes or a small 16-byte depth. The large depth is selected by a two-bit size field in a per-port configuration byte.

The interrupt threshold is the familiar four-way receive trigger level (1, 4, 8 or 14 bytes). It is multiplied by a factor of 1, 2, 4 or 8, taken from a second field of the same configuration byte. The result is clipped to the active depth. Alongside the threshold request, the block raises a character-timeout request when data sits unread and idle. It also keeps a sticky overrun flag for bytes lost to a full store.

All outputs are registered and change on the same clock edge as the fill count they describe. A FIFO clear input empties the store and drops all flags without a full reset.

Top module: `rxfifo_scaled`

## Requirements
- R1: After `rst` or `fifo_clr` the fill count is 0 and `data_ready`, `trig_irq`, `timeout_req` and `overrun` are all low. `rst` also sets `rd_data` to 0.
- R2: Bytes are popped in arrival order. A `rd_en` in a cycle with a non-zero fill count places the oldest byte on `rd_data` one clock later. A `rd_en` while empty leaves `rd_data` and the count unchanged.
- R3: When `cfg_byte[1:0]` is 2'b11, the store accepts 128 bytes. For any other value it accepts 16 bytes. `fill_cnt` always shows the number held.
- R4: `base_sel` picks the base level: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14 bytes.
- R5: `cfg_byte[5:4]` multiplies the base level: 2'b00 gives x1, 2'b01 gives x2, 2'b10 gives x4 and 2'b11 gives x8.
- R6: When the product of base level and factor exceeds the active depth, the threshold is the active depth.
- R7: `trig_irq` is high exactly while the fill count is at or above the threshold. It updates on the same edge as `fill_cnt`.
- R8: A write while the store is full and not being read drops the byte and sets `overrun`. `overrun` stays set until a `status_rd` cycle clears it. A drop in the same cycle as `status_rd` leaves it set.
- R9: A write and a read in the same cycle on a full store pop the oldest byte, accept the new one and keep the count. On an empty store, the write is accepted and the read is ignored.
- R10: `timeout_req` rises when the store is non-empty and 4 `char_tick` pulses have arrived with no write strobe and no accepted read. Any write strobe or accepted read clears it and restarts the count.
- R11: `data_ready` is high exactly while the fill count is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_clr | input | 1 | Empties the store and clears the flags |
| wr_valid | input | 1 | Received byte strobe |
| wr_data | input | 8 | Received byte |
| rd_en | input | 1 | Host pop request |
| status_rd | input | 1 | Host status read; clears overrun |
| base_sel | input | 2 | Base trigger level select |
| cfg_byte | input | 8 | Bits 5:4 are the multiplier; bits 1:0 are the depth select |
| char_tick | input | 1 | One pulse per character time |
| rd_data | output | 8 | Last popped byte |
| fill_cnt | output | 8 | Bytes held |
| data_ready | output | 1 | Store non-empty |
| trig_irq | output | 1 | Fill count at or above the scaled threshold |
| timeout_req | output | 1 | Character timeout request |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The assertions assume that `cfg_byte[1:0]` changes only while the store is empty or in a `fifo_clr` cycle. A smaller depth chosen while more bytes are held would break the bound on the count. The bench respects this by changing the configuration only together with a clear. It then varies `base_sel` and the multiplier freely within each phase, because the threshold is re-evaluated every cycle. The stimulus also drives simultaneous reads and writes at both the full and the empty boundary, where the count must hold or step by exactly one.

// File: rtl/rxfifo_pkg.sv
package rxfifo_pkg;

  // Base receive trigger level for a 2-bit select (classic four-step ladder).
  function automatic logic [3:0] base_level(input logic [1:0] sel);
    case (sel)
      2'b00:   base_level = 4'd1;
      2'b01:   base_level = 4'd4;
      2'b10:   base_level = 4'd8;
      default: base_level = 4'd14;
    endcase
  endfunction

  localparam logic [1:0] SIZE_LARGE = 2'b11;

endpackage

// File: rtl/rxfifo_store.sv
module rxfifo_store #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 128,
  parameter int SMALL_DEPTH = 16,
  localparam int AW         = $clog2(DEPTH),
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              big_mode,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              status_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  count_nxt,
  output logic              pop,
  output logic              overrun
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cap;
  logic              full, push, drop;

  assign cap  = big_mode ? CNT_W'(DEPTH) : CNT_W'(SMALL_DEPTH);
  assign full = (count >= cap);
  assign pop  = rd_en && (count != '0) && !clr;
  assign push = wr_valid && (!full || pop) && !clr;
  assign drop = wr_valid && !push && !clr;

  always_comb begin
    if (clr) count_nxt = '0;
    else     count_nxt = count + CNT_W'(push) - CNT_W'(pop);
  end

  // Storage array: plain write port, no reset, so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  // Registered read port (read-before-write on a shared address).
  always_ff @(posedge clk) begin
    if (rst)      rd_data <= '0;
    else if (pop) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)     overrun <= 1'b0;
    else if (drop)      overrun <= 1'b1;
    else if (status_rd) overrun <= 1'b0;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH)); // R3
  AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && full && !rd_en && !clr) |=> overrun); // R8
  AST_EMPTY_RD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (rd_en && count == '0 && !wr_valid && !clr) |=> (count == '0 && $stable(rd_data))); // R2
  AST_FULL_SIMUL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && rd_en && full && !clr) |=> $stable(count)); // R9

endmodule

// File: rtl/rxfifo_trigger.sv
module rxfifo_trigger #(
  parameter int DEPTH       = 128,
  parameter int SMALL_DEPTH = 16,
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int TW         = CNT_W + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             big_mode,
  input  logic [1:0]       base_sel,
  input  logic [1:0]       mult_sel,
  input  logic [CNT_W-1:0] count_nxt,
  output logic             trig_irq,
  output logic             data_ready
);
  import rxfifo_pkg::*;

  logic [TW-1:0] raw_thr, cap, thr;

  assign raw_thr = TW'(base_level(base_sel)) << mult_sel;
  assign cap     = big_mode ? TW'(DEPTH) : TW'(SMALL_DEPTH);
  assign thr     = (raw_thr > cap) ? cap : raw_thr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      trig_irq   <= 1'b0;
      data_ready <= 1'b0;
    end else begin
      trig_irq   <= (TW'(count_nxt) >= thr);
      data_ready <= (count_nxt != '0);
    end
  end

  AST_TRIG_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    trig_irq |-> data_ready); // R7

endmodule

// File: rtl/rxfifo_idle.sv
module rxfifo_idle #(
  parameter int CNT_W     = 8,
  parameter int TMO_CHARS = 4,
  localparam int IW       = $clog2(TMO_CHARS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             activity,
  input  logic             char_tick,
  input  logic [CNT_W-1:0] count_nxt,
  output logic             timeout_req
);

  logic [IW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idle_cnt    <= '0;
      timeout_req <= 1'b0;
    end else if (activity || count_nxt == '0) begin
      idle_cnt    <= '0;
      timeout_req <= 1'b0;
    end else if (char_tick && idle_cnt < IW'(TMO_CHARS)) begin
      idle_cnt    <= idle_cnt + 1'b1;
      timeout_req <= (idle_cnt + 1'b1 == IW'(TMO_CHARS));
    end
  end

  AST_TMO_CLEARED_BY_ACTIVITY: assert property (@(posedge clk) disable iff (rst)
    activity |=> !timeout_req); // R10

endmodule

// File: rtl/rxfifo_scaled.sv
module rxfifo_scaled #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 128,
  parameter int SMALL_DEPTH = 16,
  parameter int TMO_CHARS   = 4,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_clr,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              status_rd,
  input  logic [1:0]        base_sel,
  input  logic [7:0]        cfg_byte,
  input  logic              char_tick,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  fill_cnt,
  output logic              data_ready,
  output logic              trig_irq,
  output logic              timeout_req,
  output logic              overrun
);
  import rxfifo_pkg::*;

  logic             big_mode;
  logic [1:0]       mult_sel;
  logic [CNT_W-1:0] count_nxt;
  logic             pop;

  assign big_mode = (cfg_byte[1:0] == SIZE_LARGE);
  assign mult_sel = cfg_byte[5:4];

  rxfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SMALL_DEPTH(SMALL_DEPTH)) u_store (
    .clk(clk), .rst(rst), .clr(fifo_clr), .big_mode(big_mode),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_en(rd_en), .status_rd(status_rd),
    .rd_data(rd_data), .count(fill_cnt), .count_nxt(count_nxt), .pop(pop),
    .overrun(overrun)
  );

  rxfifo_trigger #(.DEPTH(DEPTH), .SMALL_DEPTH(SMALL_DEPTH)) u_trig (
    .clk(clk), .rst(rst), .clr(fifo_clr), .big_mode(big_mode),
    .base_sel(base_sel), .mult_sel(mult_sel), .count_nxt(count_nxt),
    .trig_irq(trig_irq), .data_ready(data_ready)
  );

  rxfifo_idle #(.CNT_W(CNT_W), .TMO_CHARS(TMO_CHARS)) u_idle (
    .clk(clk), .rst(rst), .clr(fifo_clr), .activity(wr_valid || pop),
    .char_tick(char_tick), .count_nxt(count_nxt), .timeout_req(timeout_req)
  );

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    fifo_clr |=> (fill_cnt == '0 && !overrun && !trig_irq && !timeout_req)); // R1
  AST_READY_MATCHES_CNT: assert property (@(posedge clk) disable iff (rst)
    data_ready |-> fill_cnt != '0); // R11

endmodule

// File: tb/rxfifo_scaled_test.sv
module rxfifo_scaled_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 4;

  logic       clk = 1'b0;
  logic       rst, fifo_clr, wr_valid, rd_en, status_rd, char_tick;
  logic [7:0] wr_data, cfg_byte, rd_data, fill_cnt;
  logic [1:0] base_sel;
  logic       data_ready, trig_irq, timeout_req, overrun;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxfifo_scaled uut (
    .clk(clk), .rst(rst), .fifo_clr(fifo_clr), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_en(rd_en), .status_rd(status_rd), .base_sel(base_sel), .cfg_byte(cfg_byte),
    .char_tick(char_tick), .rd_data(rd_data), .fill_cnt(fill_cnt),
    .data_ready(data_ready), .trig_irq(trig_irq), .timeout_req(timeout_req),
    .overrun(overrun)
  );

  int n_chk = 0, n_bad = 0;
  string phase = "R1";
  logic [7:0] q[$];
  logic [7:0] m_rd = 0;
  bit m_ovr = 0, m_tmo = 0, m_trig = 0, m_dr = 0;
  int m_idle = 0;
  logic [7:0] seq = 0;

  function automatic int thr_now();
    int b, t, e;
    b = (base_sel == 2'd0) ? 1 : (base_sel == 2'd1) ? 4 : (base_sel == 2'd2) ? 8 : 14;
    t = b * (1 << cfg_byte[5:4]);
    e = (cfg_byte[1:0] == 2'b11) ? 128 : 16;
    return (t > e) ? e : t;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (phase %s) t=%0t actual=%0d expected=%0d", req, phase, $time, act, exp);
    end
  endtask

  task automatic model_step();
    bit pop, push;
    int eff;
    eff = (cfg_byte[1:0] == 2'b11) ? 128 : 16;
    if (rst) begin
      q.delete(); m_rd = 0; m_ovr = 0; m_idle = 0; m_tmo = 0; m_trig = 0; m_dr = 0;
    end else if (fifo_clr) begin
      q.delete(); m_ovr = 0; m_idle = 0; m_tmo = 0; m_trig = 0; m_dr = 0;
    end else begin
      pop  = rd_en && q.size() > 0;
      push = wr_valid && (q.size() < eff || pop);
      if (pop)  m_rd = q.pop_front();
      if (push) q.push_back(wr_data);
      if (wr_valid && !push) m_ovr = 1;
      else if (status_rd)    m_ovr = 0;
      if (wr_valid || pop || q.size() == 0) begin
        m_idle = 0; m_tmo = 0;
      end else if (char_tick && m_idle < TMO) begin
        m_idle++; m_tmo = (m_idle == TMO);
      end
      m_trig = (q.size() >= thr_now());
      m_dr   = (q.size() > 0);
    end
  endtask

  task automatic cyc(input bit w, input bit r, input bit s = 0, input bit t = 0,
                     input bit c = 0, input bit rs = 0);
    wr_valid = w; wr_data = seq; rd_en = r; status_rd = s; char_tick = t;
    fifo_clr = c; rst = rs;
    if (w) seq = seq + 8'd37;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R2 rd_data", rd_data, m_rd);
    chk("R3 fill_cnt", fill_cnt, q.size());
    chk("R11 data_ready", data_ready, m_dr);
    chk("R7 trig_irq", trig_irq, m_trig);
    chk("R10 timeout_req", timeout_req, m_tmo);
    chk("R8 overrun", overrun, m_ovr);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (phase %s)", phase);
    summary();
    $finish;
  end

  initial begin
    rst = 1; fifo_clr = 0; wr_valid = 0; rd_en = 0; status_rd = 0; char_tick = 0;
    wr_data = 0; base_sel = 0; cfg_byte = 8'h03;
    @(negedge clk);
    phase = "R1";
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0);

    phase = "R2";
    for (int i = 0; i < 5; i++) cyc(1, 0);
    for (int i = 0; i < 6; i++) cyc(0, 1);
    cyc(0, 1);

    phase = "R4";
    for (int b = 0; b < 4; b++) begin
      base_sel = 2'(b);
      cyc(0, 0, 0, 0, 1);
      for (int i = 0; i < 16; i++) cyc(1, 0);
      for (int i = 0; i < 16; i++) cyc(0, 1);
    end

    phase = "R5";
    base_sel = 2'd1;
    for (int m = 0; m < 4; m++) begin
      cfg_byte = {2'b00, 2'(m), 4'b0011};
      cyc(0, 0, 0, 0, 1);
      for (int i = 0; i < 40; i++) cyc(1, 0);
      for (int i = 0; i < 40; i++) cyc(0, 1);
    end

    phase = "R6";
    base_sel = 2'd3; cfg_byte = 8'h30;
    cyc(0, 0, 0, 0, 1);
    for (int i = 0; i < 16; i++) cyc(1, 0);
    for (int i = 0; i < 3; i++) cyc(0, 1);
    cfg_byte = 8'h10;
    for (int i = 0; i < 3; i++) cyc(1, 0);

    phase = "R8";
    cyc(1, 0);
    cyc(1, 0);
    cyc(0, 0);
    cyc(0, 0, 1);
    cyc(1, 0, 1);
    cyc(0, 0);
    cyc(0, 0, 1);

    phase = "R3";
    base_sel = 2'd2; cfg_byte = 8'h33;
    cyc(0, 0, 0, 0, 1);
    for (int i = 0; i < 130; i++) cyc(1, 0);

    phase = "R9";
    for (int i = 0; i < 6; i++) cyc(1, 1);
    for (int i = 0; i < 128; i++) cyc(0, 1);
    cyc(1, 1);
    cyc(0, 1);
    cyc(1, 1);

    phase = "R10";
    cyc(0, 0, 0, 0, 1);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1);
    cyc(1, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1);
    cyc(0, 0);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 1);
    cyc(0, 1);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1);
    cyc(0, 1);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1);

    phase = "R7";
    for (int k = 0; k < 6; k++) begin
      cfg_byte = (k % 2 == 0) ? 8'h03 : 8'h01;
      cyc(0, 0, 0, 0, 1);
      for (int i = 0; i < 1500; i++) begin
        if (i % 100 == 0) begin
          base_sel = 2'($urandom_range(0, 3));
          cfg_byte[5:4] = 2'($urandom_range(0, 3));
        end
        cyc(($urandom_range(0, 99) < 55 - 10 * (k % 3)),
            ($urandom_range(0, 99) < 40),
            ($urandom_range(0, 99) < 5),
            ($urandom_range(0, 99) < 30));
      end
    end

    summary();
    $finish;
  end
endmodule